// File: doc/BRIEF.md
# Control-Flow Transfer Type Classifier

This block labels a recorded control-flow transfer with its kind. It receives the first opcode byte, an optional second byte used after the two-byte escape, and the ModRM byte of the instruction at the transfer source. It also receives flags that say whether the source and target addresses lie in kernel or user space, whether either address is zero, and whether the instruction bytes could be decoded at all. From these it produces a 12-bit class vector. Exactly one kind bit is set, together with one privilege bit taken from the target. The all-zero vector means the transfer could not be classified.

A branch-record filter places the block in its path and compares the class vector against a mask of wanted kinds. The opcode decode applies first. A separate rule then catches ring transitions: when a user-space source lands in kernel space and the instruction is not a deliberate system entry or software interrupt, the transfer is relabelled as a hardware interrupt, trap or fault. The result is registered, so a valid input gives a valid result on the next clock.

Top module: `xfer_class_decode`

## Requirements
- R1: If the source address is zero, the target address is zero, or the instruction is flagged as not decodable, the class vector is 0.
- R2: When the first byte is 0x0F, the second byte picks the kind. 0x05 and 0x34 give syscall (bit 4). 0x07 and 0x35 give sysret (bit 5). 0x80 to 0x8F give conditional (bit 8). Every other second byte gives 0.
- R3: Single-byte opcodes 0x70 to 0x7F and 0xE0 to 0xE3 give conditional (bit 8). 0xE9 to 0xEB give jump (bit 9). 0xE8 and 0x9A give call (bit 2). Any opcode not named in R2 to R5 gives 0.
- R4: Opcodes 0xC2, 0xC3, 0xCA and 0xCB give return (bit 3). 0xCF gives interrupt return (bit 7). 0xCC, 0xCD and 0xCE give software interrupt (bit 6).
- R5: For opcode 0xFF, the kind comes from ModRM bits [5:3]. A value of 2 or 3 gives indirect call (bit 11). A value of 4 or 5 gives jump (bit 9). Any other value gives 0. ModRM bits [7:6] and [2:0] have no effect.
- R6: A user source with a kernel target gives hardware interrupt/trap (bit 10) in place of the decoded kind. This also applies when the opcode decodes to 0. It does not apply when the kind is syscall or software interrupt.
- R7: A non-zero class carries exactly one privilege bit, set from the target: bit 0 for a user target and bit 1 for a kernel target. A zero class stays 0.
- R8: out_valid and out_class appear exactly one clock after in_valid is sampled. When in_valid is low, out_valid is low on the next clock and out_class keeps its previous value.
- R9: During and directly after reset, out_valid is 0 and out_class is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | The input fields are valid this cycle |
| op_first | input | 8 | First opcode byte |
| op_second | input | 8 | Byte that follows a 0x0F escape |
| modrm | input | 8 | ModRM byte |
| insn_ok | input | 1 | The instruction bytes could be decoded |
| src_null | input | 1 | The source address is zero |
| tgt_null | input | 1 | The target address is zero |
| src_kern | input | 1 | The source address is in kernel space |
| tgt_kern | input | 1 | The target address is in kernel space |
| out_valid | output | 1 | out_class holds a new result |
| out_class | output | 12 | Class vector: one kind bit plus one privilege bit, or 0 |

## Verification
The vector table runs every opcode group in four privilege pairings: user to user, kernel to kernel, kernel to user and user to kernel. This separates the pure opcode decode from the target-privilege tag and from the ring-transition override. Near-miss encodings sit next to each valid range. These include escape second bytes 0x7F and 0x90, single bytes 0x6F and 0xE4, ModRM values 0, 1, 6 and 7, and ModRM values that differ only outside bits [5:3]. They show that range edges and field extraction are exact. Zero addresses and undecodable bytes are paired with opcodes that would otherwise classify, including a user-to-kernel case, so that R1 is shown to take precedence over R6. Directed runs cover reset, one-cycle latency and holding of the output while in_valid is low.

// File: rtl/xfer_class_decode.sv
module xfer_class_decode #(
  parameter int BYTE_W  = 8,
  parameter int CLASS_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [BYTE_W-1:0]  op_first,
  input  logic [BYTE_W-1:0]  op_second,
  input  logic [BYTE_W-1:0]  modrm,
  input  logic               insn_ok,
  input  logic               src_null,
  input  logic               tgt_null,
  input  logic               src_kern,
  input  logic               tgt_kern,
  output logic               out_valid,
  output logic [CLASS_W-1:0] out_class
);

  localparam int B_USER = 0;
  localparam int B_KERN = 1;
  localparam int B_CALL = 2;
  localparam int B_RET  = 3;
  localparam int B_SYS  = 4;
  localparam int B_SRET = 5;
  localparam int B_INT  = 6;
  localparam int B_IRET = 7;
  localparam int B_JCC  = 8;
  localparam int B_JMP  = 9;
  localparam int B_IRQ  = 10;
  localparam int B_IND  = 11;

  localparam logic [CLASS_W-1:0] K_NONE = '0;
  localparam logic [CLASS_W-1:0] K_USER = CLASS_W'(1) << B_USER;
  localparam logic [CLASS_W-1:0] K_KERN = CLASS_W'(1) << B_KERN;
  localparam logic [CLASS_W-1:0] K_CALL = CLASS_W'(1) << B_CALL;
  localparam logic [CLASS_W-1:0] K_RET  = CLASS_W'(1) << B_RET;
  localparam logic [CLASS_W-1:0] K_SYS  = CLASS_W'(1) << B_SYS;
  localparam logic [CLASS_W-1:0] K_SRET = CLASS_W'(1) << B_SRET;
  localparam logic [CLASS_W-1:0] K_INT  = CLASS_W'(1) << B_INT;
  localparam logic [CLASS_W-1:0] K_IRET = CLASS_W'(1) << B_IRET;
  localparam logic [CLASS_W-1:0] K_JCC  = CLASS_W'(1) << B_JCC;
  localparam logic [CLASS_W-1:0] K_JMP  = CLASS_W'(1) << B_JMP;
  localparam logic [CLASS_W-1:0] K_IRQ  = CLASS_W'(1) << B_IRQ;
  localparam logic [CLASS_W-1:0] K_IND  = CLASS_W'(1) << B_IND;

  logic [2:0]         reg_ext;
  logic [CLASS_W-1:0] esc_kind;
  logic [CLASS_W-1:0] grp_kind;
  logic [CLASS_W-1:0] op_kind;
  logic [CLASS_W-1:0] ring_kind;
  logic [CLASS_W-1:0] next_class;
  logic               ring_entry;
  logic               blocked;

  assign reg_ext = modrm[5:3];
  wire unused_modrm = &{1'b0, modrm[7:6], modrm[2:0]};

  always_comb begin
    case (op_second) inside
      8'h05, 8'h34:   esc_kind = K_SYS;
      8'h07, 8'h35:   esc_kind = K_SRET;
      [8'h80:8'h8F]:  esc_kind = K_JCC;
      default:        esc_kind = K_NONE;
    endcase
  end

  always_comb begin
    case (reg_ext)
      3'd2, 3'd3: grp_kind = K_IND;
      3'd4, 3'd5: grp_kind = K_JMP;
      default:    grp_kind = K_NONE;
    endcase
  end

  always_comb begin
    case (op_first) inside
      8'h0F:                       op_kind = esc_kind;
      [8'h70:8'h7F], [8'hE0:8'hE3]: op_kind = K_JCC;
      8'hC2, 8'hC3, 8'hCA, 8'hCB:  op_kind = K_RET;
      8'hCF:                       op_kind = K_IRET;
      [8'hCC:8'hCE]:               op_kind = K_INT;
      8'hE8, 8'h9A:                op_kind = K_CALL;
      [8'hE9:8'hEB]:               op_kind = K_JMP;
      8'hFF:                       op_kind = grp_kind;
      default:                     op_kind = K_NONE;
    endcase
  end

  assign ring_entry = !src_kern && tgt_kern && op_kind != K_SYS && op_kind != K_INT;
  assign ring_kind  = ring_entry ? K_IRQ : op_kind;
  assign blocked    = src_null || tgt_null || !insn_ok;

  assign next_class = (blocked || ring_kind == K_NONE) ? K_NONE
                    : (ring_kind | (tgt_kern ? K_KERN : K_USER));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_class <= K_NONE;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_class <= next_class;
    end
  end

  a_r1_blocked_none: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && blocked |=> out_class == K_NONE);

  a_r6_user_to_kernel: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !blocked && !src_kern && tgt_kern
    |=> out_class[B_IRQ] || out_class[B_SYS] || out_class[B_INT]);

  a_r7_shape: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_class != K_NONE
    |-> $countones(out_class[1:0]) == 1 && $countones(out_class[CLASS_W-1:2]) == 1);

  a_r7_target_priv: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && tgt_kern |=> !out_class[B_USER]);

  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r8_idle_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_class));

endmodule

// File: tb/xfer_class_decode_tb_top.sv
`timescale 1ns/1ps
module xfer_class_decode_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] op_first = '0, op_second = '0, modrm = '0;
  logic insn_ok = 1'b0, src_null = 1'b0, tgt_null = 1'b0, src_kern = 1'b0, tgt_kern = 1'b0;
  logic out_valid;
  logic [11:0] out_class;

  always #4 clk = ~clk;

  xfer_class_decode dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .op_first(op_first), .op_second(op_second), .modrm(modrm),
    .insn_ok(insn_ok), .src_null(src_null), .tgt_null(tgt_null),
    .src_kern(src_kern), .tgt_kern(tgt_kern),
    .out_valid(out_valid), .out_class(out_class)
  );

  // flags {ok, src_null, tgt_null, src_kern, tgt_kern}
  localparam logic [4:0] UU = 5'b10000, KK = 5'b10011, KU = 5'b10010, UK = 5'b10001;
  // entry: {req, op_first, op_second, modrm, flags, expected}
  localparam int NV = 46;
  localparam logic [44:0] VEC [NV] = '{
    {4'd2, 8'h0F, 8'h05, 8'h00, UU, 12'h011},  // R2 syscall
    {4'd2, 8'h0F, 8'h34, 8'h00, KK, 12'h012},  // R2 sysenter form
    {4'd2, 8'h0F, 8'h07, 8'h00, KU, 12'h021},  // R2 sysret
    {4'd2, 8'h0F, 8'h35, 8'h00, KU, 12'h021},  // R2
    {4'd2, 8'h0F, 8'h80, 8'h00, UU, 12'h101},  // R2 low cond edge
    {4'd2, 8'h0F, 8'h8F, 8'h00, KK, 12'h102},  // R2 high cond edge
    {4'd2, 8'h0F, 8'h7F, 8'h00, UU, 12'h000},  // R2 below range
    {4'd2, 8'h0F, 8'h90, 8'h00, UU, 12'h000},  // R2 above range
    {4'd3, 8'h70, 8'h00, 8'h00, UU, 12'h101},  // R3
    {4'd3, 8'h7F, 8'h00, 8'h00, KK, 12'h102},  // R3
    {4'd3, 8'h6F, 8'h00, 8'h00, UU, 12'h000},  // R3 edge
    {4'd3, 8'hE0, 8'h00, 8'h00, UU, 12'h101},  // R3 loop form
    {4'd3, 8'hE3, 8'h00, 8'h00, KU, 12'h101},  // R3
    {4'd3, 8'hE4, 8'h00, 8'h00, UU, 12'h000},  // R3 edge
    {4'd3, 8'hE9, 8'h00, 8'h00, UU, 12'h201},  // R3 jump
    {4'd3, 8'hEB, 8'h00, 8'h00, KK, 12'h202},  // R3
    {4'd3, 8'hEC, 8'h00, 8'h00, UU, 12'h000},  // R3 edge
    {4'd3, 8'hE8, 8'h00, 8'h00, UU, 12'h005},  // R3 call
    {4'd3, 8'h9A, 8'h00, 8'h00, KK, 12'h006},  // R3 far call
    {4'd3, 8'h90, 8'h00, 8'h00, KK, 12'h000},  // R3 unknown
    {4'd4, 8'hC2, 8'h00, 8'h00, UU, 12'h009},  // R4 return
    {4'd4, 8'hC3, 8'h00, 8'h00, KK, 12'h00A},  // R4
    {4'd4, 8'hCA, 8'h00, 8'h00, KU, 12'h009},  // R4
    {4'd4, 8'hCB, 8'h00, 8'h00, UU, 12'h009},  // R4
    {4'd4, 8'hCF, 8'h00, 8'h00, KU, 12'h081},  // R4 iret
    {4'd4, 8'hCC, 8'h00, 8'h00, UU, 12'h041},  // R4 int
    {4'd4, 8'hCE, 8'h00, 8'h00, KK, 12'h042},  // R4
    {4'd4, 8'hC1, 8'h00, 8'h00, UU, 12'h000},  // R4 edge
    {4'd5, 8'hFF, 8'h00, 8'h10, UU, 12'h801},  // R5 ext 2
    {4'd5, 8'hFF, 8'h00, 8'h18, KK, 12'h802},  // R5 ext 3
    {4'd5, 8'hFF, 8'h00, 8'h20, UU, 12'h201},  // R5 ext 4
    {4'd5, 8'hFF, 8'h00, 8'h28, KK, 12'h202},  // R5 ext 5
    {4'd5, 8'hFF, 8'h00, 8'h00, UU, 12'h000},  // R5 ext 0
    {4'd5, 8'hFF, 8'h00, 8'h08, UU, 12'h000},  // R5 ext 1
    {4'd5, 8'hFF, 8'h00, 8'h30, UU, 12'h000},  // R5 ext 6
    {4'd5, 8'hFF, 8'h00, 8'hFF, UU, 12'h000},  // R5 ext 7 other bits set
    {4'd5, 8'hFF, 8'h00, 8'hD7, UU, 12'h801},  // R5 ext 2 other bits set
    {4'd6, 8'h0F, 8'h05, 8'h00, UK, 12'h012},  // R6 syscall kept
    {4'd6, 8'hCD, 8'h00, 8'h00, UK, 12'h042},  // R6 int kept
    {4'd6, 8'hC3, 8'h00, 8'h00, UK, 12'h402},  // R6 override
    {4'd6, 8'h90, 8'h00, 8'h00, UK, 12'h402},  // R6 unknown opcode
    {4'd6, 8'hE8, 8'h00, 8'h00, UK, 12'h402},  // R6
    {4'd1, 8'hC3, 8'h00, 8'h00, 5'b11000, 12'h000},  // R1 source zero
    {4'd1, 8'hC3, 8'h00, 8'h00, 5'b10111, 12'h000},  // R1 target zero
    {4'd1, 8'hE8, 8'h00, 8'h00, 5'b00000, 12'h000},  // R1 not decodable
    {4'd1, 8'h90, 8'h00, 8'h00, 5'b00001, 12'h000}   // R1 beats R6
  };

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%03h expected=%03h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] a, input logic [7:0] b, input logic [7:0] m, input logic [4:0] f);
    op_first = a; op_second = b; modrm = m;
    {insn_ok, src_null, tgt_null, src_kern, tgt_kern} = f;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R8 watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset valid", {11'd0, out_valid}, 12'h000);
    check("R9 reset class", out_class, 12'h000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][40:33], VEC[i][32:25], VEC[i][24:17], VEC[i][16:12]);
      in_valid = 1'b1;
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VEC[i][44:41], i), out_class, VEC[i][11:0]);
      check("R8 valid", {11'd0, out_valid}, 12'h001);
    end

    // R8 hold while idle
    @(negedge clk);
    drive(8'hE9, 8'h00, 8'h00, UU); in_valid = 1'b1;
    @(negedge clk);
    drive(8'hC3, 8'h00, 8'h00, KK); in_valid = 1'b0;
    @(negedge clk);
    check("R8 idle hold class", out_class, 12'h201);
    check("R8 idle valid low", {11'd0, out_valid}, 12'h000);
    // R8 latency exactly one edge
    in_valid = 1'b1;
    #1;
    check("R8 no early change", out_class, 12'h201);
    @(negedge clk);
    check("R8 one cycle", out_class, 12'h00A);
    in_valid = 1'b0;

    // R9 mid-run reset
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 reset clears class", out_class, 12'h000);
    check("R9 reset clears valid", {11'd0, out_valid}, 12'h000);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule